// File: doc/BRIEF.md
# OSD Horizontal Start Position Timer

This block decides, on every video line, the oscillator cycle in which each on-screen display block places its first dot. The active edge of the horizontal sync input re-arms a shared cycle counter. A single 7-bit position setting, common to all display blocks, adds four oscillator cycles per step to a fixed base offset. Each display block then waits one extra dot-clock period before its start strobe, where the dot clock is the oscillator clock divided by that block's own pre-divide ratio. Blocks with different ratios therefore start on different cycles.

Software writes the position through an 8-bit register port. The written value is held in a pending register, which reads back at once. The timer only uses it after the next vertical sync strobe, and each line keeps the position that was in force at its sync edge. The sync input is asynchronous: it passes through a synchronizer, and a polarity input chooses which edge is active. The synchronizer latency is part of the base offset.

Top module: `osd_hstart_timer`

## Requirements
- R1: After reset the register reads 0x00, the active position is 0, and no start strobe is asserted.
- R2: Block i issues its start strobe after exactly 62 + 4·N + r_i rising clock edges. Edge 1 is the first edge that samples the new active sync level. N is the active position and r_i is the block's pre-divide ratio, taken from blk_div bits [2i+1:2i], where code 0 is treated as ratio 1.
- R3: With hsync_pol_rise = 1 the rising sync edge is active; with 0 the falling edge is active. The other edge never starts a line.
- R4: Blocks with different pre-divide ratios strobe on cycles that differ by exactly the difference of their ratios.
- R5: Each start strobe is high for one clock cycle, and each block strobes once per line.
- R6: A register write updates the read-back value on the next cycle but does not change the active position until a vsync_strobe cycle copies the pending value into it.
- R7: Bit 7 of the register is not stored. Writing 1 to it has no effect, and it always reads 0.
- R8: An active sync edge arriving before a line's count finishes restarts the count from the new edge, and the aborted line issues no strobe.
- R9: The position used by a line is captured at its active sync edge, so a vsync_strobe during the line changes only later lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | OSD oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Asynchronous horizontal sync |
| hsync_pol_rise | input | 1 | 1: rising edge active, 0: falling edge active |
| vsync_strobe | input | 1 | One-cycle vertical sync pulse, clock domain |
| reg_wr | input | 1 | Position register write enable |
| reg_wdata | input | 8 | Position register write data |
| reg_rdata | output | 8 | Position register read data (pending value, bit 7 zero) |
| blk_div | input | 8 | Per-block pre-divide ratio, 2 bits per block |
| blk_start | output | 4 | Per-block one-cycle start strobes |

## Verification
On every cycle, the assertions check four things: strobes last a single cycle, a strobe only follows an armed count, an active edge reloads the counter, and the captured position stays stable during a line. They also check that the active position moves only on a vsync strobe and that read-back follows writes. Only the bench scenarios can show the exact strobe cycle for each position and ratio, the polarity choice, the abort of an interrupted line, and the per-line capture of the position.

// File: rtl/osd_hs_pkg.sv
package osd_hs_pkg;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } hs_edge_e;

    // Pre-divide code to effective ratio: code 0 behaves as ratio 1.
    function automatic int unsigned eff_div(input int unsigned code);
        return (code == 0) ? 1 : code;
    endfunction

endpackage

// File: rtl/osd_hs_edge.sv
module osd_hs_edge
    import osd_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_async,
    input  logic pol_rise,
    output logic line_edge
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t    sync_d, sync_q;
    hs_edge_e sel;

    always_comb begin
        sel       = hs_edge_e'(pol_rise);
        sync_d.s1 = hsync_async;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_comb begin
        if (sel == EDGE_RISE) line_edge = sync_q.s2 & ~sync_q.s3;
        else                  line_edge = ~sync_q.s2 & sync_q.s3;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

endmodule

// File: rtl/osd_hs_posreg.sv
module osd_hs_posreg #(
    parameter int POS_W = 7,
    localparam int REG_W = POS_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [POS_W-1:0] wr_pos,
    input  logic             vsync,
    output logic [REG_W-1:0] rdata,
    output logic [POS_W-1:0] act_pos
);

    typedef struct packed {
        logic [POS_W-1:0] pend;
        logic [POS_W-1:0] act;
    } preg_t;

    preg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (vsync) r_d.act  = r_q.pend;
        if (wr_en) r_d.pend = wr_pos;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata   = {{(REG_W-POS_W){1'b0}}, r_q.pend};
    assign act_pos = r_q.act;

    // R6: active value copies the pending value on a vsync strobe
    a_r6_vsync_apply: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> act_pos == $past(r_q.pend));

    // R6: without a vsync strobe the active value holds
    a_r6_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync |=> $stable(act_pos));

    // R7: read-back follows a write with bit 7 cleared
    a_r7_readback: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rdata == {1'b0, $past(wr_pos)});

endmodule

// File: rtl/osd_hs_delay.sv
module osd_hs_delay
    import osd_hs_pkg::*;
#(
    parameter int NUM_BLK  = 4,
    parameter int POS_W    = 7,
    parameter int DIV_W    = 2,
    parameter int STEP_CYC = 4,
    parameter int BASE_OFS = 62,
    parameter int LOAD_CNT = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     line_edge,
    input  logic [POS_W-1:0]         act_pos,
    input  logic [NUM_BLK*DIV_W-1:0] blk_div,
    output logic [NUM_BLK-1:0]       blk_start
);

    localparam int MAX_DIV = (1 << DIV_W) - 1;
    localparam int MAX_T   = BASE_OFS + STEP_CYC * ((1 << POS_W) - 1) + MAX_DIV;
    localparam int CNT_W   = $clog2(MAX_T + 1);

    typedef struct packed {
        logic               busy;
        logic [CNT_W-1:0]   elapsed;
        logic [POS_W-1:0]   pos;
        logic [NUM_BLK-1:0] pulse;
    } dly_t;

    dly_t             st_d, st_q;
    logic [CNT_W-1:0] base_t;
    logic [CNT_W-1:0] last_t;
    logic [CNT_W-1:0] tgt [NUM_BLK];

    always_comb begin
        base_t = CNT_W'(BASE_OFS) + CNT_W'(STEP_CYC * int'(st_q.pos));
        last_t = base_t + CNT_W'(MAX_DIV);
    end

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_tgt
        assign tgt[b] = base_t + CNT_W'(eff_div(int'(blk_div[b*DIV_W +: DIV_W])));
    end

    always_comb begin
        st_d       = st_q;
        st_d.pulse = '0;
        if (line_edge) begin
            st_d.busy    = 1'b1;
            st_d.elapsed = CNT_W'(LOAD_CNT);
            st_d.pos     = act_pos;
        end else if (st_q.busy) begin
            st_d.elapsed = st_q.elapsed + 1'b1;
            for (int i = 0; i < NUM_BLK; i++) begin
                if (st_d.elapsed == tgt[i]) st_d.pulse[i] = 1'b1;
            end
            if (st_d.elapsed == last_t) st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign blk_start = st_q.pulse;

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_chk
        // R5: a strobe never lasts two cycles
        a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            blk_start[b] |=> !blk_start[b]);
    end

    // R2: strobes only come out of an armed count
    a_r2_strobe_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        (|blk_start) |-> $past(st_q.busy));

    // R8: an active edge restarts the count from the load value
    a_r8_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
        line_edge |=> (st_q.busy && st_q.elapsed == CNT_W'(LOAD_CNT)));

    // R9: the captured position stays fixed for the line
    a_r9_pos_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !line_edge) |=> $stable(st_q.pos));

endmodule

// File: rtl/osd_hstart_timer.sv
module osd_hstart_timer #(
    parameter int NUM_BLK  = 4,
    parameter int POS_W    = 7,
    parameter int DIV_W    = 2,
    parameter int STEP_CYC = 4,
    parameter int BASE_OFS = 62,
    localparam int REG_W   = POS_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hsync_in,
    input  logic                     hsync_pol_rise,
    input  logic                     vsync_strobe,
    input  logic                     reg_wr,
    input  logic [REG_W-1:0]         reg_wdata,
    output logic [REG_W-1:0]         reg_rdata,
    input  logic [NUM_BLK*DIV_W-1:0] blk_div,
    output logic [NUM_BLK-1:0]       blk_start
);

    // Edges consumed by the synchronizer before the count is armed.
    localparam int LOAD_CNT = 3;

    logic             line_edge;
    logic [POS_W-1:0] act_pos;
    logic             wr_msb_unused;

    assign wr_msb_unused = reg_wdata[REG_W-1];

    osd_hs_edge u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .hsync_async (hsync_in),
        .pol_rise    (hsync_pol_rise),
        .line_edge   (line_edge)
    );

    osd_hs_posreg #(.POS_W(POS_W)) u_posreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_pos  (reg_wdata[POS_W-1:0]),
        .vsync   (vsync_strobe),
        .rdata   (reg_rdata),
        .act_pos (act_pos)
    );

    osd_hs_delay #(
        .NUM_BLK  (NUM_BLK),
        .POS_W    (POS_W),
        .DIV_W    (DIV_W),
        .STEP_CYC (STEP_CYC),
        .BASE_OFS (BASE_OFS),
        .LOAD_CNT (LOAD_CNT)
    ) u_delay (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_edge (line_edge),
        .act_pos   (act_pos),
        .blk_div   (blk_div),
        .blk_start (blk_start)
    );

endmodule

// File: tb/osd_hstart_timer_tb.sv
module osd_hstart_timer_tb;

    localparam int NB  = 4;
    localparam int WIN = 700;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync = 1'b0;
    logic       pol_rise = 1'b1;
    logic       vsync = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] div = 8'h00;
    logic [3:0] bstart;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    osd_hstart_timer u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .hsync_in       (hsync),
        .hsync_pol_rise (pol_rise),
        .vsync_strobe   (vsync),
        .reg_wr         (wr),
        .reg_wdata      (wdata),
        .reg_rdata      (rdata),
        .blk_div        (div),
        .blk_start      (bstart)
    );

    function automatic int exp_t(int n, int code);
        return 62 + 4 * n + ((code == 0) ? 1 : code);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_reg(logic [7:0] v);
        @(negedge clk); wr = 1'b1; wdata = v;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic pulse_vsync();
        @(negedge clk); vsync = 1'b1;
        @(negedge clk); vsync = 1'b0;
    endtask

    // Watches WIN cycles starting with the edge after the call; checks strobe timing.
    task automatic capture(int n, bit mid_vsync, string req);
        int first[NB];
        int cnt[NB];
        for (int b = 0; b < NB; b++) begin first[b] = -1; cnt[b] = 0; end
        for (int k = 1; k <= WIN; k++) begin
            @(posedge clk); @(negedge clk);
            for (int b = 0; b < NB; b++) begin
                if (bstart[b]) begin
                    cnt[b]++;
                    if (first[b] < 0) first[b] = k;
                end
            end
            if (mid_vsync) vsync = (k == 20);
        end
        vsync = 1'b0;
        for (int b = 0; b < NB; b++) begin
            check(first[b] == exp_t(n, int'(div[2*b +: 2])), req, first[b],
                  exp_t(n, int'(div[2*b +: 2])));
            check(cnt[b] == 1, "R5 one strobe per line", cnt[b], 1);
        end
    endtask

    task automatic drive_active();
        @(negedge clk); hsync = pol_rise;
    endtask

    task automatic drive_idle();
        @(negedge clk); hsync = ~pol_rise;
        repeat (6) @(negedge clk);
    endtask

    task automatic run_line(int n, string req);
        drive_active();
        capture(n, 1'b0, req);
        drive_idle();
    endtask

    // Switching polarity together with the idle level makes a non-active edge.
    task automatic set_pol(logic p);
        int seen = 0;
        @(negedge clk); pol_rise = p; hsync = ~p;
        for (int k = 0; k < WIN; k++) begin
            @(negedge clk);
            if (bstart != 0) seen++;
        end
        check(seen == 0, "R3 non-active edge starts no line", seen, 0);
    endtask

    initial begin
        void'($urandom(32'h0005_eed1));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rdata == 8'h00, "R1 reset readback", rdata, 0);
        check(bstart == 4'h0, "R1 no strobe after reset", bstart, 0);

        // R2 / R4 at position 0 with mixed ratios (codes 1,2,3,0)
        div = {2'd0, 2'd3, 2'd2, 2'd1};
        run_line(0, "R2 position 0");

        // R7: bit 7 ignored, reads 0; R2 at the largest position
        write_reg(8'hFF);
        check(rdata == 8'h7F, "R7 bit7 reads zero", rdata, 8'h7F);
        pulse_vsync();
        run_line(127, "R2 position 127");

        // R6: write without vsync keeps the old timing
        write_reg(8'h05);
        check(rdata == 8'h05, "R6 pending readback", rdata, 5);
        run_line(127, "R6 no vsync keeps old position");
        pulse_vsync();
        run_line(5, "R6 applied after vsync");

        // R9: vsync in the middle of a line affects later lines only
        write_reg(8'h10);
        drive_active();
        capture(5, 1'b1, "R9 current line keeps its position");
        drive_idle();
        run_line(16, "R9 next line uses new position");

        // R8: restart before the count ends
        drive_active();
        repeat (30) @(negedge clk);
        hsync = ~pol_rise;
        repeat (4) @(negedge clk);
        hsync = pol_rise;
        capture(16, 1'b0, "R8 restart from new edge");
        drive_idle();

        // R3: falling-edge polarity
        set_pol(1'b0);
        div = {2'd2, 2'd2, 2'd1, 2'd3};
        run_line(16, "R3 falling edge active");
        set_pol(1'b1);

        // Random lines
        for (int it = 0; it < 14; it++) begin
            int n;
            n = int'($urandom_range(0, 127));
            div = 8'($urandom);
            if ($urandom_range(0, 3) == 0) set_pol(~pol_rise);
            write_reg({1'($urandom), 7'(n)});
            check(rdata == {1'b0, 7'(n)}, "R7 random readback", rdata, n);
            pulse_vsync();
            run_line(n, "R2 R4 random line");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule